// File: doc/BRIEF.md
# Asynchronous Static Memory Host Controller

This block sits between a synchronous request port and an asynchronous 32K x 8 static memory. A host issues one request per cycle while `ready` is high. Each request is either a byte write or a byte read. The controller plays out the matching chip-select, write-strobe and output-enable waveforms on the memory pins and returns read data with a one-cycle `rvalid` pulse.

Every timing rule of the memory is given in nanoseconds as a parameter. These rules are the write pulse, address-valid-to-end-of-write, data-valid-to-end-of-write, write and read cycle times, access time, output-enable access and write recovery. Each one is rounded up to whole cycles of a clock-period parameter. A write begins with one select-only cycle. The write strobe then stays low for the longest of the derived windows and rises one cycle before the select does. The host data driver stays on through that rising edge. A read holds select and output-enable low for the longest read window. The bus is sampled on the clock edge that ends this window. A recovery gap then follows before `ready` returns.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` and `rvalid` are 0. A few cycles after reset is released, `ready` is 1.
- R2: `ready` is 1 only while no access is in progress, and then all strobes are inactive and the data driver is off. A request is taken when `req` and `ready` are both 1; `req` while `ready` is 0 is ignored.
- R3: A read (`req_we`=0) drives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 for max(ceil(tACC), ceil(tOE), ceil(tRC)) cycles. The controller then captures `mem_dq_in` into `rdata` and raises `rvalid` for exactly one cycle, max(...)+1 cycles after acceptance.
- R4: A write (`req_we`=1) lowers `mem_ce_n` one cycle before `mem_we_n` falls. `mem_we_n` is low only while `mem_ce_n` is low, and it rises one cycle before `mem_ce_n`. The memory stores `req_wdata` at `req_addr`.
- R5: `mem_addr` changes only on an edge where `mem_ce_n` was 1 in the preceding cycle, so it is constant while the memory is selected.
- R6: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and `mem_dq_out` holds the write data. The driver is still on, with unchanged data, in the cycle `mem_we_n` rises.
- R7: The write strobe stays low for max(ceil(tWP), ceil(tAW)-1, ceil(tDW)-1, 1) cycles, so every write window is met in whole cycles.
- R8: After acceptance, `ready` stays 0 for 1 + pulse + 1 + max(ceil(tWR), ceil(tWC) - (pulse+2), 1) cycles on a write and for the read window + max(ceil(tWR), 1) cycles on a read.
- R9: `mem_we_n` and `mem_oe_n` are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (15) | Byte address |
| req_wdata | input | DW (8) | Write byte |
| ready | output | 1 | Controller can accept a request |
| rvalid | output | 1 | One-cycle read data valid |
| rdata | output | DW (8) | Read byte |
| mem_addr | output | AW (15) | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DW (8) | Data toward memory |
| mem_dq_in | input | DW (8) | Data from memory |
| mem_dq_oe | output | 1 | Host data driver enable |

## Verification
The bound checker watches the pin rules on every cycle. These rules are: no contention between the host driver and memory output enable, a write strobe only inside a select, no write strobe together with output enable, an address that moves only while deselected, data held at the strobe's rising edge, a minimum strobe width, a quiet bus while ready, and single-cycle `rvalid`. Other properties need the bench's memory model and scenarios. The model returns valid bytes only once the access time has elapsed. The scenarios also cover busy-time lengths, the position of `rvalid`, stored and returned bytes, and requests held high while busy being ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4,
    ST_REC  = 3'd5
  } ctrl_state_e;

  // nanoseconds rounded up to whole clock cycles
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load || !done;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!done) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW       = 4,
  parameter int WPUL_LEN = 6,
  parameter int WREC_LEN = 1,
  parameter int RACC_LEN = 7,
  parameter int RREC_LEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          done,
  output logic          load,
  output logic [CW-1:0] load_val,
  output ctrl_state_e   state_d,
  output ctrl_state_e   state_q
);

  localparam logic [CW-1:0] LD_ONE  = '0;
  localparam logic [CW-1:0] LD_WPUL = CW'(WPUL_LEN - 1);
  localparam logic [CW-1:0] LD_WREC = CW'(WREC_LEN - 1);
  localparam logic [CW-1:0] LD_RACC = CW'(RACC_LEN - 1);
  localparam logic [CW-1:0] LD_RREC = CW'(RREC_LEN - 1);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = LD_ONE;
    unique case (state_q)
      ST_IDLE: if (req) begin
        load = 1'b1;
        if (req_we) begin
          state_d  = ST_WSET;
          load_val = LD_ONE;
        end else begin
          state_d  = ST_RACC;
          load_val = LD_RACC;
        end
      end
      ST_WSET: if (done) begin
        state_d = ST_WPUL; load = 1'b1; load_val = LD_WPUL;
      end
      ST_WPUL: if (done) begin
        state_d = ST_WHLD; load = 1'b1; load_val = LD_ONE;
      end
      ST_WHLD: if (done) begin
        state_d = ST_REC; load = 1'b1; load_val = LD_WREC;
      end
      ST_RACC: if (done) begin
        state_d = ST_REC; load = 1'b1; load_val = LD_RREC;
      end
      ST_REC: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_RC_NS   = 70,
  parameter int T_WP_NS   = 55,
  parameter int T_AW_NS   = 65,
  parameter int T_DW_NS   = 30,
  parameter int T_WC_NS   = 70,
  parameter int T_WR_NS   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int ACC_C    = ns2cyc(T_ACC_NS, CLK_NS);
  localparam int OE_C     = ns2cyc(T_OE_NS, CLK_NS);
  localparam int RC_C     = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_C     = ns2cyc(T_WP_NS, CLK_NS);
  localparam int AWIN_C   = ns2cyc(T_AW_NS, CLK_NS);
  localparam int DWIN_C   = ns2cyc(T_DW_NS, CLK_NS);
  localparam int WC_C     = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WR_C     = ns2cyc(T_WR_NS, CLK_NS);
  localparam int WPUL_LEN = imax(imax(WP_C, AWIN_C - 1), imax(DWIN_C - 1, 1));
  localparam int WREC_LEN = imax(imax(WR_C, WC_C - (WPUL_LEN + 2)), 1);
  localparam int RACC_LEN = imax(imax(ACC_C, OE_C), imax(RC_C, 1));
  localparam int RREC_LEN = imax(WR_C, 1);
  localparam int CW       = $clog2(imax(imax(WPUL_LEN, WREC_LEN), RACC_LEN) + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ctrl_state_e   state_d, state_q;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          accept, rd_capture;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_fsm #(
    .CW       (CW),
    .WPUL_LEN (WPUL_LEN),
    .WREC_LEN (WREC_LEN),
    .RACC_LEN (RACC_LEN),
    .RREC_LEN (RREC_LEN)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req      (req),
    .req_we   (req_we),
    .done     (tmr_done),
    .load     (tmr_load),
    .load_val (tmr_val),
    .state_d  (state_d),
    .state_q  (state_q)
  );

  assign ready      = (state_q == ST_IDLE);
  assign accept     = ready && req;
  assign rd_capture = (state_q == ST_RACC) && tmr_done;

  // strobe decode from the next state, registered so pins never glitch
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    ce_n_d  = 1'b1;
    we_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    dq_oe_d = 1'b0;
    unique case (state_d)
      ST_WSET, ST_WHLD: begin ce_n_d = 1'b0; dq_oe_d = 1'b1; end
      ST_WPUL: begin ce_n_d = 1'b0; we_n_d = 1'b0; dq_oe_d = 1'b1; end
      ST_RACC: begin ce_n_d = 1'b0; oe_n_d = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rvalid    <= 1'b0;
    end else begin
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      rvalid    <= rd_capture;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)     rdata <= '0;
    else if (rd_capture) rdata <= mem_dq_in;
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 55
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);

  localparam logic [31:0] WP_MIN = 32'(ns2cyc(T_WP_NS, CLK_NS));

  logic [31:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 32'd1;
    else                we_low_cnt <= '0;
  end

  AST_NO_BUS_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R4

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R9

  AST_ADDR_MOVES_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(mem_ce_n)); // R5

  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

  AST_DATA_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out))); // R6

  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= WP_MIN)); // R7

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R3

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .AW      (AW),
  .DW      (DW),
  .CLK_NS  (CLK_NS),
  .T_WP_NS (T_WP_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .rvalid     (rvalid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NACC  = cdiv(70);
  localparam int NWP   = cdiv(55);
  localparam int NAWIN = cdiv(65);
  localparam int NDWIN = cdiv(30);
  localparam int PULSE = mx(mx(NWP, NAWIN - 1), mx(NDWIN - 1, 1));
  localparam int NRA   = mx(mx(NACC, cdiv(35)), cdiv(70));
  localparam int WBUSY = 1 + PULSE + 1 + mx(mx(cdiv(5), cdiv(70) - (PULSE + 2)), 1);
  localparam int RBUSY = NRA + mx(cdiv(5), 1);
  localparam logic [AW-1:0] POKE_A = 15'h1234;

  logic          clk, rst_n, req, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_chk, n_fail;
  bit done_flag;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model and pin monitor
  logic [7:0] chipmem [int];
  logic [7:0] expmem  [int];
  logic [7:0] dq_drive;
  int rd_cnt, we_lo, ce_lo, dq_on;
  logic p_we_n, p_ce_n;
  logic [AW-1:0] p_addr;
  assign mem_dq_in = dq_drive;

  function automatic logic [7:0] chip_rd(input logic [AW-1:0] a);
    return chipmem.exists(int'(a)) ? chipmem[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
    return expmem.exists(int'(a)) ? expmem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_cnt = 0; we_lo = 0; ce_lo = 0; dq_on = 0;
      p_we_n = 1'b1; p_ce_n = 1'b1; p_addr = mem_addr;
      dq_drive = 8'hEE;
    end else begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++; else rd_cnt = 0;
      dq_drive = (rd_cnt >= NACC) ? chip_rd(mem_addr) : 8'hEE;
      if (mem_dq_oe && !mem_oe_n) chk(0, "R6 driver on with oe low", 1, 0);
      if (!mem_we_n && !mem_oe_n) chk(0, "R9 we and oe both low", 0, 1);
      if (!mem_we_n && mem_ce_n)  chk(0, "R4 we low outside ce", 1, 0);
      if (mem_addr != p_addr && !p_ce_n)
        chk(0, "R5 address moved while selected", int'(mem_addr), int'(p_addr));
      if (!mem_we_n && p_we_n)
        chk(!p_ce_n, "R4 ce low before we falls", int'(p_ce_n), 0);
      if (mem_we_n && !p_we_n) begin
        chk(we_lo >= NWP, "R7 write pulse cycles", we_lo, NWP);
        chk(ce_lo >= NAWIN, "R7 address valid to end of write", ce_lo, NAWIN);
        chk(dq_on >= NDWIN, "R7 data valid to end of write", dq_on, NDWIN);
        chk(mem_dq_oe && !mem_ce_n, "R6 data held at we rise", int'(mem_dq_oe), 1);
        chipmem[int'(mem_addr)] = mem_dq_out;
      end
      we_lo = mem_we_n ? 0 : we_lo + 1;
      ce_lo = mem_ce_n ? 0 : ce_lo + 1;
      dq_on = mem_dq_oe ? dq_on + 1 : 0;
      p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_addr = mem_addr;
    end
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit poke);
    int busy, rv_cnt, rv_at;
    logic [7:0] rv_dat;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    if (we) expmem[int'(a)] = d;
    @(negedge clk);
    if (poke) begin
      req = 1'b1; req_we = 1'b1; req_addr = POKE_A; req_wdata = 8'h5A;
    end else req = 1'b0;
    busy = 0; rv_cnt = 0; rv_at = 0; rv_dat = 8'h00;
    while (!ready && busy < 100) begin
      busy++;
      if (rvalid) begin rv_cnt++; rv_at = busy; rv_dat = rdata; end
      @(negedge clk);
    end
    req = 1'b0;
    chk(rvalid == 1'b0, "R3 rvalid low once ready", int'(rvalid), 0);
    if (we) begin
      chk(busy == WBUSY, "R8 write busy cycles", busy, WBUSY);
      chk(rv_cnt == 0, "R3 no rvalid on write", rv_cnt, 0);
    end else begin
      chk(busy == RBUSY, "R8 read busy cycles", busy, RBUSY);
      chk(rv_cnt == 1, "R3 one rvalid per read", rv_cnt, 1);
      chk(rv_at == NRA + 1, "R3 rvalid position", rv_at, NRA + 1);
      chk(rv_dat == exp_rd(a), "R3 read data", int'(rv_dat), int'(exp_rd(a)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    n_chk = 0; n_fail = 0; done_flag = 0;
    seed_v = $urandom(32'd4711);
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes inactive in reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    chk(!mem_dq_oe && !rvalid, "R1 driver and rvalid off in reset",
        int'({mem_dq_oe, rvalid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready, "R1 ready after reset", int'(ready), 1);
    chk(mem_ce_n && !mem_dq_oe, "R2 idle bus quiet", int'(mem_dq_oe), 0);

    // directed corners
    do_op(1'b1, 15'h7FFF, 8'hA5, 1'b0);
    do_op(1'b1, 15'h0000, 8'h3C, 1'b0);
    do_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    do_op(1'b0, 15'h0000, 8'h00, 1'b0);
    do_op(1'b0, 15'h2222, 8'h00, 1'b0);
    do_op(1'b1, 15'h4005, 8'hFF, 1'b1);
    do_op(1'b0, 15'h4005, 8'h00, 1'b1);
    do_op(1'b1, 15'h4005, 8'h00, 1'b0);
    do_op(1'b0, 15'h4005, 8'h00, 1'b0);

    // constrained random
    for (int i = 0; i < 250; i++) begin
      logic [AW-1:0] a;
      a = 15'h4000 + AW'($urandom_range(0, 31));
      do_op(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)),
            ($urandom_range(0, 7) == 0));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // R2 requests held during busy never reached the memory
    chk(!chipmem.exists(int'(POKE_A)), "R2 request while busy ignored",
        int'(chipmem.exists(int'(POKE_A))), 0);
    // R4 every written byte landed at its address
    foreach (expmem[k])
      chk(chip_rd(AW'(k)) == expmem[k], "R4 stored byte", int'(chip_rd(AW'(k))),
          int'(expmem[k]));

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule